// File: doc/BRIEF.md
# Real-Time Clock Slow-Clock Selector and Seconds Prescaler

This block produces the slow clock for a real-time-clock domain and a one-per-second tick from it. It can derive the slow clock internally, by dividing a 24 MHz reference down to 31.250 kHz. It can instead pass through an external crystal clock, which runs at either 32.768 kHz or 32.000 kHz. Two configuration inputs choose among the three cases. The change of source may be made while both clocks are running. A cross-coupled pair of enable flops turns the old clock off and only then turns the new one on, so the output never carries a shortened pulse.

A prescaler runs on the selected slow clock and counts it down to a one-cycle tick. Its divisor follows the selection: 31250, 32768 or 32000 by default. The new divisor takes effect only when the count in progress ends, so no second comes out short. The block also reports which frequency the configuration selects. It flags whether the crystal that configuration expects is reported present by the two presence inputs. Every divide ratio is a parameter, so a bench can use small values.

Top module: `rtc_slowclk_gen`

## Requirements
- R1: While rst_n is low, tick_1hz is 0 and the internal path is enabled. After reset is released, clk_slow follows the divided reference until src_sel is raised.
- R2: With src_sel = 0, clk_slow has a period of REF_DIV reference cycles and is high for exactly REF_DIV/2 of them.
- R3: With src_sel = 1, clk_slow reproduces clk_xtal, with the same period, once the handover has completed.
- R4: When src_sel changes while both clocks run, clk_slow has no high or low phase shorter than the shorter half period of the two source clocks. The two source enables are never on together.
- R5: The interval between ticks, counted in clk_slow cycles, is DIV_INT when src_sel = 0. It is DIV_XA when src_sel = 1 and freq_sel = 0, and DIV_XB when src_sel = 1 and freq_sel = 1.
- R6: tick_1hz is high for exactly one clk_slow cycle at a time.
- R7: After a change of selection, the new divisor is loaded at the first terminal count. Every tick interval therefore equals either the old divisor or the new one.
- R8: freq_code follows the configuration inputs directly: 2'b00 when src_sel = 0, 2'b01 when src_sel = 1 and freq_sel = 0, and 2'b10 when src_sel = 1 and freq_sel = 1. The value 2'b11 never appears.
- R9: xtal_ok is 1 when src_sel = 0. When src_sel = 1 it is 1 only if the presence flag for the selected frequency is high and the other flag is low. xtal_a_present stands for the 32.768 kHz crystal and xtal_b_present for the 32.000 kHz crystal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 24 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_xtal | input | 1 | Optional external crystal clock |
| src_sel | input | 1 | 0: divided reference, 1: crystal |
| freq_sel | input | 1 | Crystal frequency: 0 for 32.768 kHz, 1 for 32.000 kHz |
| xtal_a_present | input | 1 | A 32.768 kHz crystal is fitted |
| xtal_b_present | input | 1 | A 32.000 kHz crystal is fitted |
| clk_slow | output | 1 | Selected slow clock |
| tick_1hz | output | 1 | One-slow-cycle pulse once per divisor period |
| freq_code | output | 2 | Selected frequency code (see R8) |
| xtal_ok | output | 1 | Selected crystal is reported present (see R9) |

## Verification
freq_code and xtal_ok are combinational outputs, so they are checked 1 ns after each input change. The tick is registered on a rising edge of clk_slow, so it is sampled on the following falling edge. Tick intervals are counted in falling edges of clk_slow. A tick interval, period or pulse width is compared only after the bench has waited several whole ticks past a change of selection. This allows for the two-flop synchroniser and the handover of the mux. During the switch of R7, every interval is recorded from the moment freq_sel changes. Pulse widths of clk_slow are timed at every edge, including those seen while the source switches.

// File: rtl/rtc_slowclk_pkg.sv
`timescale 1ns/1ps
package rtc_slowclk_pkg;

   typedef enum logic [1:0] {
      FREQ_INT = 2'b00,
      FREQ_XA  = 2'b01,
      FREQ_XB  = 2'b10
   } rtc_freq_e;

   function automatic rtc_freq_e decode_freq(input logic src, input logic fsel);
      if (!src)     return FREQ_INT;
      else if (fsel) return FREQ_XB;
      else          return FREQ_XA;
   endfunction

endpackage

// File: rtl/rtc_ref_div.sv
`timescale 1ns/1ps
module rtc_ref_div #(
   parameter int DIV = 768
) (
   input  logic clk_i,
   input  logic rst_n,
   output logic clk_o
);
   localparam int HALF = DIV / 2;
   localparam int CW   = $clog2(HALF + 1);

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("rtc_ref_div: DIV must be even and at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          clk_q;

   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         clk_q <= 1'b0;
      end else if (cnt_q == CW'(HALF - 1)) begin
         cnt_q <= '0;
         clk_q <= ~clk_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign clk_o = clk_q;
endmodule

// File: rtl/rtc_glitchless_mux.sv
`timescale 1ns/1ps
module rtc_glitchless_mux (
   input  logic clk_a,
   input  logic clk_b,
   input  logic rst_n,
   input  logic sel_b,
   output logic en_a,
   output logic en_b,
   output logic clk_o
);
   logic a_arm_q, b_arm_q;

   // clock A side: arm on rising edge, enable on falling edge
   always_ff @(posedge clk_a or negedge rst_n) begin
      if (!rst_n) a_arm_q <= 1'b1;
      else        a_arm_q <= ~sel_b & ~en_b;
   end

   always_ff @(negedge clk_a or negedge rst_n) begin
      if (!rst_n) en_a <= 1'b1;
      else        en_a <= a_arm_q;
   end

   // clock B side
   always_ff @(posedge clk_b or negedge rst_n) begin
      if (!rst_n) b_arm_q <= 1'b0;
      else        b_arm_q <= sel_b & ~en_a;
   end

   always_ff @(negedge clk_b or negedge rst_n) begin
      if (!rst_n) en_b <= 1'b0;
      else        en_b <= b_arm_q;
   end

   assign clk_o = (clk_a & en_a) | (clk_b & en_b);
endmodule

// File: rtl/rtc_tick_prescaler.sv
`timescale 1ns/1ps
module rtc_tick_prescaler
   import rtc_slowclk_pkg::*;
#(
   parameter int DIV_INT     = 31250,
   parameter int DIV_XA      = 32768,
   parameter int DIV_XB      = 32000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n,
   input  logic src_async,
   input  logic fsel_async,
   output logic tick_o
);
   localparam int MAXD = (DIV_INT > DIV_XA) ?
                         ((DIV_INT > DIV_XB) ? DIV_INT : DIV_XB) :
                         ((DIV_XA  > DIV_XB) ? DIV_XA  : DIV_XB);
   localparam int CW   = $clog2(MAXD + 1);

   generate
      if (DIV_INT < 2 || DIV_XA < 2 || DIV_XB < 2) begin : g_bad_div
         $error("rtc_tick_prescaler: every divisor must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rtc_tick_prescaler: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // per-bit synchroniser chains, one bit each for source and frequency
   logic [SYNC_STAGES-1:0] src_sync_q, fsel_sync_q;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_n) begin
               if (!rst_n) begin
                  src_sync_q[0]  <= 1'b0;
                  fsel_sync_q[0] <= 1'b0;
               end else begin
                  src_sync_q[0]  <= src_async;
                  fsel_sync_q[0] <= fsel_async;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_n) begin
               if (!rst_n) begin
                  src_sync_q[s]  <= 1'b0;
                  fsel_sync_q[s] <= 1'b0;
               end else begin
                  src_sync_q[s]  <= src_sync_q[s-1];
                  fsel_sync_q[s] <= fsel_sync_q[s-1];
               end
            end
         end
      end
   endgenerate

   rtc_freq_e     code_s;
   logic [CW-1:0] div_sel;
   logic [CW-1:0] cnt_q;

   always_comb begin
      code_s = decode_freq(src_sync_q[SYNC_STAGES-1], fsel_sync_q[SYNC_STAGES-1]);
      unique case (code_s)
         FREQ_XA: div_sel = CW'(DIV_XA);
         FREQ_XB: div_sel = CW'(DIV_XB);
         default: div_sel = CW'(DIV_INT);
      endcase
   end

   // reload only at terminal count so the running interval is never cut
   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= CW'(DIV_INT - 1);
         tick_o <= 1'b0;
      end else if (cnt_q == '0) begin
         cnt_q  <= div_sel - 1'b1;
         tick_o <= 1'b1;
      end else begin
         cnt_q  <= cnt_q - 1'b1;
         tick_o <= 1'b0;
      end
   end
endmodule

// File: rtl/rtc_slowclk_gen.sv
`timescale 1ns/1ps
module rtc_slowclk_gen
   import rtc_slowclk_pkg::*;
#(
   parameter int REF_DIV     = 768,
   parameter int DIV_INT     = 31250,
   parameter int DIV_XA      = 32768,
   parameter int DIV_XB      = 32000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_ref,
   input  logic       rst_n,
   input  logic       clk_xtal,
   input  logic       src_sel,
   input  logic       freq_sel,
   input  logic       xtal_a_present,
   input  logic       xtal_b_present,
   output logic       clk_slow,
   output logic       tick_1hz,
   output logic [1:0] freq_code,
   output logic       xtal_ok
);
   logic div_clk;
   logic en_int, en_xtal;

   rtc_ref_div #(.DIV(REF_DIV)) u_ref_div (
      .clk_i (clk_ref),
      .rst_n (rst_n),
      .clk_o (div_clk)
   );

   rtc_glitchless_mux u_mux (
      .clk_a (div_clk),
      .clk_b (clk_xtal),
      .rst_n (rst_n),
      .sel_b (src_sel),
      .en_a  (en_int),
      .en_b  (en_xtal),
      .clk_o (clk_slow)
   );

   rtc_tick_prescaler #(
      .DIV_INT     (DIV_INT),
      .DIV_XA      (DIV_XA),
      .DIV_XB      (DIV_XB),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_presc (
      .clk_i      (clk_slow),
      .rst_n      (rst_n),
      .src_async  (src_sel),
      .fsel_async (freq_sel),
      .tick_o     (tick_1hz)
   );

   always_comb begin
      freq_code = decode_freq(src_sel, freq_sel);
      if (!src_sel)      xtal_ok = 1'b1;
      else if (freq_sel) xtal_ok = xtal_b_present & ~xtal_a_present;
      else               xtal_ok = xtal_a_present & ~xtal_b_present;
   end
endmodule

// File: rtl/rtc_slowclk_chk.sv
`timescale 1ns/1ps
module rtc_slowclk_chk #(
   parameter int REF_DIV = 768
) (
   input logic       clk_ref,
   input logic       rst_n,
   input logic       src_sel,
   input logic       div_clk,
   input logic       en_int,
   input logic       en_xtal,
   input logic       clk_slow,
   input logic       tick_1hz,
   input logic [1:0] freq_code,
   input logic       xtal_ok
);
   localparam int HALF = REF_DIV / 2;
   localparam int GW   = $clog2(REF_DIV + 2);

   logic [GW-1:0] gap_q;
   logic          seen_q;

   // reference cycles since the divided clock last changed
   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (!$stable(div_clk)) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   // R2: divided clock changes every HALF reference cycles
   a_r2_half_period: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!$stable(div_clk) && seen_q) |-> (gap_q == GW'(HALF - 1)));

   // R4: the two source enables are never on together
   always_comb begin
      if (rst_n === 1'b1) begin
         a_r4_one_enable: assert (!(en_int && en_xtal));
      end
   end

   // R6: tick lasts one slow cycle
   a_r6_single_tick: assert property (@(posedge clk_slow) disable iff (!rst_n)
      tick_1hz |=> !tick_1hz);

   // R8: unused code never appears
   a_r8_code_legal: assert property (@(posedge clk_ref) disable iff (!rst_n)
      freq_code != 2'b11);

   // R9: internal path always reports ok
   a_r9_internal_ok: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !src_sel |-> xtal_ok);
endmodule

bind rtc_slowclk_gen rtc_slowclk_chk #(.REF_DIV(REF_DIV)) u_chk (
   .clk_ref   (clk_ref),
   .rst_n     (rst_n),
   .src_sel   (src_sel),
   .div_clk   (div_clk),
   .en_int    (en_int),
   .en_xtal   (en_xtal),
   .clk_slow  (clk_slow),
   .tick_1hz  (tick_1hz),
   .freq_code (freq_code),
   .xtal_ok   (xtal_ok)
);

// File: tb/rtc_slowclk_gen_tb.sv
`timescale 1ns/1ps
module rtc_slowclk_gen_tb;
   localparam int  REF_DIV = 4;
   localparam int  DIV_INT = 5;
   localparam int  DIV_XA  = 8;
   localparam int  DIV_XB  = 6;
   localparam real T_REF   = 5.0;
   localparam real T_XTAL  = 14.0;
   localparam real MIN_PH  = 7.0;

   logic       clk_ref = 1'b0, clk_xtal = 1'b0, rst_n = 1'b0;
   logic       src_sel = 1'b0, freq_sel = 1'b0, xa = 1'b0, xb = 1'b0;
   logic       clk_slow, tick_1hz, xtal_ok;
   logic [1:0] freq_code;

   int n_run = 0, n_fail = 0;

   always #(T_REF / 2.0)  clk_ref  = ~clk_ref;
   always #(T_XTAL / 2.0) clk_xtal = ~clk_xtal;

   rtc_slowclk_gen #(
      .REF_DIV(REF_DIV), .DIV_INT(DIV_INT), .DIV_XA(DIV_XA), .DIV_XB(DIV_XB)
   ) u_dut (
      .clk_ref(clk_ref), .rst_n(rst_n), .clk_xtal(clk_xtal),
      .src_sel(src_sel), .freq_sel(freq_sel),
      .xtal_a_present(xa), .xtal_b_present(xb),
      .clk_slow(clk_slow), .tick_1hz(tick_1hz),
      .freq_code(freq_code), .xtal_ok(xtal_ok)
   );

   // ---------------- monitors ----------------
   bit  mon_en = 0;
   int  glitches = 0, wide_ticks = 0;
   real t_edge = 0.0, t_rise = -1.0, last_period = 0.0, last_high = 0.0;
   int  slow_cnt = 0, last_iv = 0, hist_n = 0;
   int  hist [0:31];
   bit  prev_tick = 0;

   always @(clk_slow) begin
      if (mon_en && ($realtime - t_edge) < MIN_PH - 0.01) glitches++;
      t_edge = $realtime;
   end

   always @(posedge clk_slow) begin
      if (t_rise >= 0.0) last_period = $realtime - t_rise;
      t_rise = $realtime;
   end

   always @(negedge clk_slow) begin
      last_high = $realtime - t_rise;
      if (rst_n) begin
         slow_cnt++;
         if (tick_1hz && prev_tick) wide_ticks++;
         if (tick_1hz) begin
            last_iv = slow_cnt;
            if (hist_n < 32) hist[hist_n] = slow_cnt;
            hist_n++;
            slow_cnt = 0;
         end
         prev_tick = tick_1hz;
      end
   end

   // ---------------- helpers ----------------
   function automatic logic [1:0] exp_code(input logic s, input logic f);
      return !s ? 2'b00 : (f ? 2'b10 : 2'b01);
   endfunction

   function automatic logic exp_ok(input logic s, input logic f, input logic a, input logic b);
      if (!s) return 1'b1;
      return f ? (b && !a) : (a && !b);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         do @(negedge clk_slow); while (!tick_1hz);
      end
      #1;
   endtask

   function automatic int rnd(input real x);
      return $rtoi(x + 0.5);
   endfunction

   // ---------------- watchdog ----------------
   initial begin
      #200000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      void'($urandom(32'h5EED_0C1C));
      #3;
      // R1 reset state
      chk("R1 tick in reset", int'(tick_1hz), 0);
      chk("R1 code in reset", int'(freq_code), 0);
      #20;
      @(negedge clk_ref) rst_n = 1'b1;
      mon_en = 1;

      wait_ticks(3);
      chk("R1 internal path after reset, period", rnd(last_period), rnd(REF_DIV * T_REF));
      chk("R2 high time", rnd(last_high), rnd(REF_DIV * T_REF / 2.0));
      chk("R5 internal interval", last_iv, DIV_INT);

      // R8/R9 constrained random, holds long enough for the mux handover
      for (int i = 0; i < 30; i++) begin
         @(negedge clk_ref);
         src_sel  = 1'($urandom_range(0, 1));
         freq_sel = 1'($urandom_range(0, 1));
         if ($urandom_range(0, 3) == 0) begin
            xa = 1'b1; xb = 1'b1;
         end else begin
            xa = 1'($urandom_range(0, 1));
            xb = xa ? 1'b0 : 1'($urandom_range(0, 1));
         end
         #1;
         chk("R8 freq_code", int'(freq_code), int'(exp_code(src_sel, freq_sel)));
         chk("R9 xtal_ok", int'(xtal_ok), int'(exp_ok(src_sel, freq_sel, xa, xb)));
         #($urandom_range(100, 300));
      end

      // directed corners for R9
      src_sel = 1'b1; freq_sel = 1'b0; xa = 1'b0; xb = 1'b0; #1;
      chk("R9 no crystal fitted", int'(xtal_ok), 0);
      xa = 1'b1; xb = 1'b1; #1;
      chk("R9 both flags high", int'(xtal_ok), 0);
      xa = 1'b1; xb = 1'b0; #1;
      chk("R9 matching crystal", int'(xtal_ok), 1);

      // R3, R5 crystal at first frequency
      wait_ticks(4);
      chk("R3 slow period follows crystal", rnd(last_period), rnd(T_XTAL));
      chk("R5 crystal A interval", last_iv, DIV_XA);

      // R7 change frequency while running
      @(negedge clk_slow);
      hist_n = 0;
      freq_sel = 1'b1;
      wait_ticks(5);
      begin
         int bad = 0;
         for (int i = 0; i < hist_n && i < 32; i++)
            if (hist[i] != DIV_XA && hist[i] != DIV_XB) bad++;
         chk("R7 no shortened interval", bad, 0);
      end
      chk("R5 crystal B interval", last_iv, DIV_XB);

      // back to internal
      src_sel = 1'b0;
      wait_ticks(4);
      chk("R5 internal interval after return", last_iv, DIV_INT);
      chk("R2 period after return", rnd(last_period), rnd(REF_DIV * T_REF));

      chk("R6 tick one cycle wide", wide_ticks, 0);
      chk("R4 no short phase on slow clock", glitches, 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule